// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block decides which clocks run in a small microcontroller and when they start again. Besides normal operation there are two low-power modes. In idle, the core clock stops while peripherals, the oscillator and the DAC drivers keep running. In full power-down, the oscillator stops, every clock is gated and the DAC outputs are released to high impedance. Software enters a mode by writing a one-cycle request strobe. The block leaves the mode on its own when a qualifying interrupt arrives, and it raises a one-cycle wake pulse so that the CPU services that interrupt and then resumes after the instruction that entered the mode.

Idle ends on any enabled interrupt request. Power-down ends on the periodic timer interrupt with no enable needed. The serial interrupt ends power-down only when its own wake-enable bit is set, and the same holds for external interrupt 0. No other interrupt ends power-down. On a power-down wake the oscillator is turned on first. The clocks come back only after a programmable stabilisation count. A hardware reset, or a power cycle, which reaches the block as the same reset, returns the block to normal mode from any state.

All pins are plain control and status levels. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the block is in normal mode: `core_clk_en`, `periph_clk_en`, `osc_en` and `dac_oe` are 1 and `wake_evt` is 0.
- R2: A `req_idle` strobe sampled in normal mode, without `req_pdown`, gives on the next cycle `core_clk_en`=0 while `periph_clk_en`, `osc_en` and `dac_oe` stay 1.
- R3: In idle, any interrupt input (timer, serial, external 0, or any bit of `irq_other`) restores `core_clk_en` on the next cycle together with a one-cycle `wake_evt`. The power-down wake enables play no part in this.
- R4: A `req_pdown` strobe sampled in normal mode gives on the next cycle `osc_en`, `core_clk_en`, `periph_clk_en` and `dac_oe` all 0. It wins when `req_idle` is sampled in the same cycle.
- R5: In power-down, `irq_timer` ends the mode with no enable bit: `osc_en` rises on the next cycle.
- R6: In power-down, `irq_serial` wakes only when `wake_en_serial`=1, and `irq_ext0` wakes only when `wake_en_ext0`=1. Bits of `irq_other` never wake. A non-qualifying interrupt leaves every output unchanged.
- R7: After a power-down wake, `osc_en` is 1 while `core_clk_en`, `periph_clk_en` and `dac_oe` stay 0 for exactly `stab_count`+1 cycles. The three then rise together with a one-cycle `wake_evt`.
- R8: `rst_n` low in any mode, including during stabilisation, returns the block to the R1 state without a `wake_evt`.
- R9: Request strobes are ignored outside normal mode. Each mode request is cleared when the mode is left, so after a wake the block stays in normal mode until a new strobe arrives.
- R10: Interrupts arriving in normal mode change no output and produce no `wake_evt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low hardware or power-on reset |
| req_idle | input | 1 | One-cycle software strobe requesting idle |
| req_pdown | input | 1 | One-cycle software strobe requesting full power-down |
| wake_en_serial | input | 1 | Allows the serial interrupt to end power-down |
| wake_en_ext0 | input | 1 | Allows external interrupt 0 to end power-down |
| irq_timer | input | 1 | Periodic timer interrupt request |
| irq_serial | input | 1 | Serial (I2C/SPI) interrupt request |
| irq_ext0 | input | 1 | External interrupt 0 request |
| irq_other | input | NUM_OTHER | Other enabled interrupt requests |
| stab_count | input | CNT_W | Oscillator stabilisation length minus one, in cycles |
| core_clk_en | output | 1 | Core clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Oscillator run enable |
| dac_oe | output | 1 | DAC output driver enable (0 = high impedance) |
| wake_evt | output | 1 | One-cycle pulse telling the CPU to service the waking interrupt |

## Verification
The bench builds the block with `CNT_W`=4 and `NUM_OTHER`=2. This makes the widest stabilisation value, 15, cheap to reach, so the 16-cycle window is checked next to the zero-count case. With two other-interrupt bits, both an upper and a lower bit can be shown to wake idle while being ignored in power-down. The bench also covers every combination of wake-enable and serial or external interrupt, and it applies reset in the middle of a stabilisation count.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_PDOWN = 2'd2,
    PM_WARM  = 2'd3
  } pm_state_t;
endpackage

// File: rtl/pmc_wake_qual.sv
module pmc_wake_qual #(
  parameter int NUM_OTHER = 4
) (
  input  logic                 wake_en_serial,
  input  logic                 wake_en_ext0,
  input  logic                 irq_timer,
  input  logic                 irq_serial,
  input  logic                 irq_ext0,
  input  logic [NUM_OTHER-1:0] irq_other,
  output logic                 idle_wake,
  output logic                 pdown_wake
);
  logic other_any;

  generate
    if (NUM_OTHER > 0) begin : g_other
      assign other_any = |irq_other;
    end else begin : g_no_other
      assign other_any = 1'b0;
    end
  endgenerate

  // idle: any request at all; power-down: timer always, others gated
  assign idle_wake  = irq_timer | irq_serial | irq_ext0 | other_any;
  assign pdown_wake = irq_timer | (irq_serial & wake_en_serial)
                    | (irq_ext0 & wake_en_ext0);
endmodule

// File: rtl/pmc_stab_timer.sv
module pmc_stab_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             done
);
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      remain_q <= '0;
    else if (load)
      remain_q <= load_val;
    else if (run && (remain_q != '0))
      remain_q <= remain_q - 1'b1;
  end

  assign done = (remain_q == '0);
endmodule

// File: rtl/pmc_gate_decode.sv
module pmc_gate_decode
  import pmc_pkg::*;
(
  input  pm_state_t state,
  output logic      core_clk_en,
  output logic      periph_clk_en,
  output logic      osc_en,
  output logic      dac_oe
);
  always_comb begin
    core_clk_en   = 1'b0;
    periph_clk_en = 1'b0;
    osc_en        = 1'b1;
    dac_oe        = 1'b0;
    unique case (state)
      PM_RUN: begin
        core_clk_en   = 1'b1;
        periph_clk_en = 1'b1;
        dac_oe        = 1'b1;
      end
      PM_IDLE: begin
        periph_clk_en = 1'b1;
        dac_oe        = 1'b1;
      end
      PM_PDOWN: osc_en = 1'b0;
      PM_WARM:  osc_en = 1'b1;
      default:  osc_en = 1'b1;
    endcase
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int NUM_OTHER = 4,
  parameter int CNT_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_idle,
  input  logic                 req_pdown,
  input  logic                 wake_en_serial,
  input  logic                 wake_en_ext0,
  input  logic                 irq_timer,
  input  logic                 irq_serial,
  input  logic                 irq_ext0,
  input  logic [NUM_OTHER-1:0] irq_other,
  input  logic [CNT_W-1:0]     stab_count,
  output logic                 core_clk_en,
  output logic                 periph_clk_en,
  output logic                 osc_en,
  output logic                 dac_oe,
  output logic                 wake_evt
);
  pm_state_t state_q, state_d;
  logic      idle_wake, pdown_wake, stab_done;
  logic      warm_load, wake_d;

  pmc_wake_qual #(.NUM_OTHER(NUM_OTHER)) u_qual (
    .wake_en_serial (wake_en_serial),
    .wake_en_ext0   (wake_en_ext0),
    .irq_timer      (irq_timer),
    .irq_serial     (irq_serial),
    .irq_ext0       (irq_ext0),
    .irq_other      (irq_other),
    .idle_wake      (idle_wake),
    .pdown_wake     (pdown_wake)
  );

  pmc_stab_timer #(.CNT_W(CNT_W)) u_stab (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (warm_load),
    .load_val (stab_count),
    .run      (state_q == PM_WARM),
    .done     (stab_done)
  );

  pmc_gate_decode u_gate (
    .state         (state_q),
    .core_clk_en   (core_clk_en),
    .periph_clk_en (periph_clk_en),
    .osc_en        (osc_en),
    .dac_oe        (dac_oe)
  );

  always_comb begin
    state_d   = state_q;
    warm_load = 1'b0;
    wake_d    = 1'b0;
    unique case (state_q)
      PM_RUN: begin
        if (req_pdown)     state_d = PM_PDOWN;   // power-down wins
        else if (req_idle) state_d = PM_IDLE;
      end
      PM_IDLE: if (idle_wake) begin
        state_d = PM_RUN;
        wake_d  = 1'b1;
      end
      PM_PDOWN: if (pdown_wake) begin
        state_d   = PM_WARM;
        warm_load = 1'b1;
      end
      PM_WARM: if (stab_done) begin
        state_d = PM_RUN;
        wake_d  = 1'b1;
      end
      default: state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PM_RUN;
      wake_evt <= 1'b0;
    end else begin
      state_q  <= state_d;
      wake_evt <= wake_d;
    end
  end
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
  parameter int NUM_OTHER = 4,
  parameter int CNT_W     = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_idle,
  input logic                 req_pdown,
  input logic                 wake_en_serial,
  input logic                 wake_en_ext0,
  input logic                 irq_timer,
  input logic                 irq_serial,
  input logic                 irq_ext0,
  input logic [NUM_OTHER-1:0] irq_other,
  input logic [CNT_W-1:0]     stab_count,
  input logic                 core_clk_en,
  input logic                 periph_clk_en,
  input logic                 osc_en,
  input logic                 dac_oe,
  input logic                 wake_evt
);
  logic in_idle, in_pd, in_warm, any_irq, pd_qual;
  logic [CNT_W:0]   warm_cycles;
  logic [CNT_W-1:0] held_stab;

  assign in_idle = !core_clk_en && periph_clk_en;
  assign in_pd   = !osc_en;
  assign in_warm = osc_en && !periph_clk_en;
  assign any_irq = irq_timer || irq_serial || irq_ext0 || (|irq_other);
  assign pd_qual = irq_timer || (irq_serial && wake_en_serial)
                 || (irq_ext0 && wake_en_ext0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_cycles <= '0;
      held_stab   <= '0;
    end else begin
      warm_cycles <= in_warm ? warm_cycles + 1'b1 : '0;
      if (in_pd) held_stab <= stab_count;
    end
  end

  a_r2_idle_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && req_idle && !req_pdown) |=>
      (!core_clk_en && periph_clk_en && osc_en && dac_oe));

  a_r3_idle_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && any_irq) |=> (core_clk_en && wake_evt));

  a_r4_pdown_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && req_pdown) |=>
      (!osc_en && !core_clk_en && !periph_clk_en && !dac_oe));

  a_r5_timer_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pd && irq_timer) |=> (osc_en && !core_clk_en));

  a_r6_pdown_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pd && !pd_qual) |=> (!osc_en && !wake_evt));

  a_r7_warm_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (in_warm && (warm_cycles < {1'b0, held_stab})) |=>
      (!core_clk_en && !dac_oe && osc_en));

  a_r7_warm_end: assert property (@(posedge clk) disable iff (!rst_n)
    (in_warm && (warm_cycles == {1'b0, held_stab})) |=>
      (core_clk_en && periph_clk_en && dac_oe && wake_evt));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> !wake_evt);

  a_r9_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && !any_irq) |=> (in_idle && !wake_evt));

  a_r10_run_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && !req_idle && !req_pdown) |=> (core_clk_en && !wake_evt));
endmodule

bind pwr_mode_ctrl pmc_checker #(.NUM_OTHER(NUM_OTHER), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_idle(req_idle), .req_pdown(req_pdown),
  .wake_en_serial(wake_en_serial), .wake_en_ext0(wake_en_ext0),
  .irq_timer(irq_timer), .irq_serial(irq_serial), .irq_ext0(irq_ext0),
  .irq_other(irq_other), .stab_count(stab_count),
  .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
  .osc_en(osc_en), .dac_oe(dac_oe), .wake_evt(wake_evt)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;
  localparam int NO = 2;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_idle = 0, req_pdown = 0, en_ser = 0, en_ext0 = 0;
  logic i_tim = 0, i_ser = 0, i_ext0 = 0;
  logic [NO-1:0] i_oth = '0;
  logic [CW-1:0] stab = '0;
  logic core_en, per_en, osc, dac, wake;

  int checks = 0, errors = 0;
  bit finished = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  pwr_mode_ctrl #(.NUM_OTHER(NO), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_idle(req_idle), .req_pdown(req_pdown),
    .wake_en_serial(en_ser), .wake_en_ext0(en_ext0),
    .irq_timer(i_tim), .irq_serial(i_ser), .irq_ext0(i_ext0),
    .irq_other(i_oth), .stab_count(stab),
    .core_clk_en(core_en), .periph_clk_en(per_en), .osc_en(osc),
    .dac_oe(dac), .wake_evt(wake)
  );

  // reference model: 0 normal, 1 idle, 2 power-down, 3 stabilising
  int m_mode = 0;
  int m_left = 0;
  bit m_wake = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_left = 0; m_wake = 0;
    end else begin
      m_wake = 0;
      case (m_mode)
        0: if (req_pdown) m_mode = 2; else if (req_idle) m_mode = 1;
        1: if (i_tim || i_ser || i_ext0 || (i_oth != 0)) begin
             m_mode = 0; m_wake = 1;
           end
        2: if (i_tim || (i_ser && en_ser) || (i_ext0 && en_ext0)) begin
             m_mode = 3; m_left = int'(stab);
           end
        default: if (m_left == 0) begin m_mode = 0; m_wake = 1; end
                 else m_left = m_left - 1;
      endcase
    end
  end

  task automatic chk(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("core_clk_en",   core_en, m_mode == 0);
    chk("periph_clk_en", per_en,  m_mode <= 1);
    chk("osc_en",        osc,     m_mode != 2);
    chk("dac_oe",        dac,     m_mode <= 1);
    chk("wake_evt",      wake,    m_wake);
  endtask

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
      compare();
    end
  endtask

  task automatic clr();
    req_idle = 0; req_pdown = 0; i_tim = 0; i_ser = 0; i_ext0 = 0; i_oth = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    tag = "R1"; compare();
    rst_n = 1; tick(2);

    tag = "R10"; i_tim = 1; i_ser = 1; i_ext0 = 1; i_oth = 2'b11; tick(); clr(); tick(2);

    tag = "R2"; req_idle = 1; tick(); clr(); tick(2);
    tag = "R9"; req_pdown = 1; req_idle = 1; tick(); clr(); tick(2);
    tag = "R3"; i_oth = 2'b10; tick(); clr();
    tag = "R9"; tick(3);
    tag = "R3"; req_idle = 1; tick(); clr(); en_ser = 0; i_ser = 1; tick(); clr(); tick();
    req_idle = 1; tick(); clr(); i_ext0 = 1; tick(); clr(); tick();
    req_idle = 1; tick(); clr(); i_tim = 1; tick(); clr(); tick();

    tag = "R4"; stab = 4'd3; req_pdown = 1; req_idle = 1; tick(); clr(); tick(2);
    tag = "R6"; i_oth = 2'b01; tick(); i_oth = 2'b10; tick(); clr();
    i_ser = 1; tick(); clr(); i_ext0 = 1; tick(); clr(); tick();
    tag = "R9"; req_idle = 1; tick(); clr(); tick();
    tag = "R7"; en_ser = 1; i_ser = 1; tick(); clr(); tick(6);
    tag = "R9"; tick(3);

    tag = "R6"; en_ser = 0; en_ext0 = 1; stab = 4'd0; req_pdown = 1; tick(); clr();
    i_ser = 1; tick(); clr(); i_ext0 = 1; tick(); clr(); tick(3);
    tag = "R5"; en_ext0 = 0; stab = 4'd15; req_pdown = 1; tick(); clr(); tick();
    i_tim = 1; tick(); clr();
    tag = "R7"; i_oth = 2'b11; tick(); clr(); tick(18);

    tag = "R8"; req_pdown = 1; tick(); clr(); tick(); rst_n = 0; tick(); rst_n = 1; tick(2);
    req_pdown = 1; stab = 4'd9; tick(); clr(); i_tim = 1; tick(); clr(); tick(3);
    rst_n = 0; tick(); rst_n = 1; tick(12);
    req_idle = 1; tick(); clr(); rst_n = 0; tick(); rst_n = 1; tick(2);

    finish_run();
  end
endmodule